// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside a processor core and decides, both when reset ends and while the core runs, whether a condition sends the core into debug mode or into ordinary exception handling. During system reset it samples a debug strobe pin. A high pin at that point arms debug mode. If the pin then stays high through a short, fixed window after reset release, the block steers the core straight into debug mode instead of letting it fetch the reset vector. If the pin drops inside the window, the block hands the core to the reset vector for a normal start.

At run time, four event sources are qualified by a per-event enable register:

| Index | Source |
|-------|--------|
| 0 | non-maskable interrupt pin |
| 1 | check stop |
| 2 | machine check |
| 3 | instruction protection fault |

An event whose enable bit is set raises the internal freeze output whether or not debug mode is armed. It also enters debug mode when debug mode is armed. Every other event is routed to regular interrupt handling. Each event's cause is recorded in a cause register whose bits clear when software writes ones to them. A single exit pulse leaves debug mode and drops freeze.

All decisions leave the block as registered outputs:

- `enter_debug` and `take_interrupt` are one-cycle pulses.
- `fetch_reset_vec` is a one-cycle pulse.
- `in_debug`, `freeze` and `dbg_enabled` are levels.

Control and status pins are plain wires. There is no streaming data path and so no back-pressure.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: `dbg_enabled` takes the value of `dbg_pin` seen on the last clock edge with `rst_n` low, and keeps it until the next reset. It is never the case that `enter_debug` pulses while `dbg_enabled` is 0.
- R2: With debug armed, if `dbg_pin` is high on each of the first WINDOW rising edges after reset release, then after edge WINDOW the following all hold: `enter_debug` pulses for one cycle, `in_debug` and `freeze` go to 1, and bit 31 of the cause register is set.
- R3: With debug armed, if `dbg_pin` is low on edge k (k in 1..WINDOW) after release, `fetch_reset_vec` pulses after edge k and no debug entry follows. With debug not armed, `fetch_reset_vec` pulses after edge 1.
- R4: The enable register resets to all ones. A write with `reg_sel` = 0 loads `reg_wdata` into it. Bit i enables event i (index 0 to 3 in the table above).
- R5: In run mode and outside debug, an event i whose enable bit is set, with debug armed, causes one `enter_debug` pulse on the next cycle, and sets `in_debug` and `freeze`.
- R6: An event cycle that is not routed to debug (debug not armed, or no requested event enabled) gives exactly one `take_interrupt` pulse on the next cycle. `freeze` rises on the next cycle exactly when some requested event is enabled.
- R7: Each requested event i sets cause bit i. A write with `reg_sel` = 1 clears the cause bits where `reg_wdata` is 1. A set in the same cycle as a clear of that bit wins.
- R8: An `exit_dbg` pulse clears `in_debug` and `freeze` on the next edge.
- R9: Events are ignored while `in_debug` is 1 and during the post-reset window. Ignored events produce no pulse and no change to the cause register.
- R10: `enter_debug` and `take_interrupt` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, synchronous, active low |
| dbg_pin | input | 1 | Debug strobe pin, sampled during and after reset |
| evt_req | input | NUM_EVT | Event requests, one bit per source |
| exit_dbg | input | 1 | Pulse to leave debug mode |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the cause register |
| reg_wdata | input | DATA_W | Write data |
| en_reg_o | output | DATA_W | Current enable register |
| cause_o | output | DATA_W | Current cause register |
| dbg_enabled | output | 1 | Debug mode armed during reset |
| fetch_reset_vec | output | 1 | Pulse: core starts at the reset vector |
| enter_debug | output | 1 | Pulse: core enters debug mode |
| take_interrupt | output | 1 | Pulse: core takes regular exception handling |
| in_debug | output | 1 | Core is in debug mode |
| freeze | output | 1 | Internal freeze to peripheral modules |

## Verification
The bench builds the block with four event sources and a post-reset window of three cycles. The short window lets every release pattern be swept: the pin falling at each window edge, or never falling, with debug both armed and not armed. With four sources, every combination of request vector, enable mask and armed state fits in a full sweep of 512 cases. Each case covers entry, ignored events while in debug, cause clearing and exit.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic {PH_BOOT, PH_RUN} phase_e;
  localparam logic SEL_ENABLE = 1'b0;
  localparam logic SEL_CAUSE  = 1'b1;
endpackage

// File: rtl/dbg_boot_window.sv
module dbg_boot_window
  import dbg_entry_pkg::*;
#(
  parameter int WINDOW = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic dbg_en_o,
  output logic run_o,
  output logic go_vec_o,
  output logic go_dbg_o
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             boot;

  assign boot     = (phase_q == PH_BOOT);
  assign go_vec_o = boot && (!en_q || !pin);
  assign go_dbg_o = boot && en_q && pin && (cnt_q == LAST);
  assign dbg_en_o = en_q;
  assign run_o    = (phase_q == PH_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= pin;
      phase_q <= PH_BOOT;
      cnt_q   <= '0;
    end else if (boot) begin
      if (go_vec_o || go_dbg_o) phase_q <= PH_RUN;
      else                      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dbg_evt_router.sv
module dbg_evt_router #(
  parameter int NUM_EVT = 4
) (
  input  logic [NUM_EVT-1:0] evt_req,
  input  logic [NUM_EVT-1:0] evt_en,
  input  logic               active,
  input  logic               dbg_en,
  output logic               qual_any,
  output logic               to_debug,
  output logic               to_int,
  output logic [NUM_EVT-1:0] rec_vec
);
  logic [NUM_EVT-1:0] qual;
  logic               any_req;

  always_comb begin
    for (int i = 0; i < NUM_EVT; i++) begin
      qual[i]    = active && evt_req[i] && evt_en[i];
      rec_vec[i] = active && evt_req[i];
    end
    any_req  = |rec_vec;
    qual_any = |qual;
    to_debug = qual_any && dbg_en;
    to_int   = any_req && !to_debug;
  end
endmodule

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg #(
  parameter int DATA_W   = 32,
  parameter int NUM_EVT  = 4,
  parameter int BOOT_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:0] set_evt,
  input  logic              set_boot,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] cause_o
);
  logic [DATA_W-1:0] set_full;
  logic [DATA_W-1:0] clr_eff;
  logic [DATA_W-1:0] cause_q;

  always_comb begin
    set_full                = '0;
    set_full[NUM_EVT-1:0]   = set_evt;
    set_full[BOOT_BIT]      = set_boot;
    clr_eff                 = clr_we ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q & ~clr_eff) | set_full;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 4,
  parameter int WINDOW  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbg_pin,
  input  logic [NUM_EVT-1:0] evt_req,
  input  logic               exit_dbg,
  input  logic               reg_wr_en,
  input  logic               reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  en_reg_o,
  output logic [DATA_W-1:0]  cause_o,
  output logic               dbg_enabled,
  output logic               fetch_reset_vec,
  output logic               enter_debug,
  output logic               take_interrupt,
  output logic               in_debug,
  output logic               freeze
);
  localparam int BOOT_BIT = DATA_W - 1;

  logic               run, go_vec, go_dbg;
  logic               qual_any, to_debug, to_int;
  logic [NUM_EVT-1:0] rec_vec;
  logic [DATA_W-1:0]  en_q;
  logic               in_dbg_q, frz_q, enter_q, take_q, fetch_q;

  dbg_boot_window #(.WINDOW(WINDOW)) u_boot (
    .clk(clk), .rst_n(rst_n), .pin(dbg_pin),
    .dbg_en_o(dbg_enabled), .run_o(run),
    .go_vec_o(go_vec), .go_dbg_o(go_dbg)
  );

  dbg_evt_router #(.NUM_EVT(NUM_EVT)) u_route (
    .evt_req(evt_req), .evt_en(en_q[NUM_EVT-1:0]),
    .active(run && !in_dbg_q), .dbg_en(dbg_enabled),
    .qual_any(qual_any), .to_debug(to_debug), .to_int(to_int),
    .rec_vec(rec_vec)
  );

  dbg_cause_reg #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .BOOT_BIT(BOOT_BIT)) u_cause (
    .clk(clk), .rst_n(rst_n), .set_evt(rec_vec), .set_boot(go_dbg),
    .clr_we(reg_wr_en && (reg_sel == SEL_CAUSE)), .clr_mask(reg_wdata),
    .cause_o(cause_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '1;
      in_dbg_q <= 1'b0;
      frz_q    <= 1'b0;
      enter_q  <= 1'b0;
      take_q   <= 1'b0;
      fetch_q  <= 1'b0;
    end else begin
      enter_q <= go_dbg || to_debug;
      take_q  <= to_int;
      fetch_q <= go_vec;
      if (reg_wr_en && (reg_sel == SEL_ENABLE)) en_q <= reg_wdata;
      if (go_dbg || to_debug) in_dbg_q <= 1'b1;
      else if (exit_dbg)      in_dbg_q <= 1'b0;
      if (go_dbg || qual_any) frz_q <= 1'b1;
      else if (exit_dbg)      frz_q <= 1'b0;
    end
  end

  assign en_reg_o        = en_q;
  assign in_debug        = in_dbg_q;
  assign freeze          = frz_q;
  assign enter_debug     = enter_q;
  assign take_interrupt  = take_q;
  assign fetch_reset_vec = fetch_q;
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic exit_dbg,
  input logic dbg_enabled,
  input logic fetch_reset_vec,
  input logic enter_debug,
  input logic take_interrupt,
  input logic in_debug,
  input logic freeze
);
  assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_debug && take_interrupt));

  assert_entry_needs_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enter_debug |-> dbg_enabled);

  assert_entry_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enter_debug |-> (in_debug && freeze));

  assert_exit_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_debug && exit_dbg) |=> (!in_debug && !freeze));

  assert_quiet_in_debug_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug |=> (!enter_debug && !take_interrupt));

  assert_vector_not_debug_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_reset_vec |-> (!in_debug && !enter_debug));
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exit_dbg(exit_dbg),
  .dbg_enabled(dbg_enabled), .fetch_reset_vec(fetch_reset_vec),
  .enter_debug(enter_debug), .take_interrupt(take_interrupt),
  .in_debug(in_debug), .freeze(freeze)
);

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
  localparam int NE = 4;
  localparam int W  = 3;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0, dbg_pin = 1'b0, exit_dbg = 1'b0;
  logic [NE-1:0] evt_req = '0;
  logic          reg_wr_en = 1'b0, reg_sel = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] en_reg_o, cause_o;
  logic          dbg_enabled, fetch_reset_vec, enter_debug, take_interrupt, in_debug, freeze;

  int checks = 0;
  int errors = 0;

  dbg_entry_ctrl #(.DATA_W(DW), .NUM_EVT(NE), .WINDOW(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_pin(dbg_pin), .evt_req(evt_req),
    .exit_dbg(exit_dbg), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .en_reg_o(en_reg_o), .cause_o(cause_o),
    .dbg_enabled(dbg_enabled), .fetch_reset_vec(fetch_reset_vec),
    .enter_debug(enter_debug), .take_interrupt(take_interrupt),
    .in_debug(in_debug), .freeze(freeze)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_boot(input logic en, input int low_at);
    int fetch_e, enter_e, decide_e;
    rst_n = 1'b0; dbg_pin = en; evt_req = '0; reg_wr_en = 1'b0; exit_dbg = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 enable reset", en_reg_o, '1);
    chk("R2 cause reset", cause_o, '0);
    chk("R8 state reset", {30'd0, in_debug, freeze}, '0);
    fetch_e  = !en ? 1 : (low_at <= W ? low_at : 0);
    enter_e  = (en && low_at > W) ? W : 0;
    decide_e = (fetch_e != 0) ? fetch_e : enter_e;
    rst_n = 1'b1;
    for (int s = 1; s <= W + 1; s++) begin
      dbg_pin = en && (s < low_at);
      evt_req = (s < decide_e) ? '1 : '0;
      @(negedge clk);
      chk("R1 armed", dbg_enabled, en);
      chk("R3 vector pulse", fetch_reset_vec, (s == fetch_e));
      chk("R2 entry pulse", enter_debug, (s == enter_e));
      chk("R9 boot events ignored", take_interrupt, 0);
    end
    evt_req = '0; dbg_pin = 1'b0;
    chk("R2 boot cause", cause_o, (enter_e != 0) ? 32'h8000_0000 : 32'h0);
    chk("R2 boot in_debug", in_debug, (enter_e != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int en = 0; en < 2; en++)
      for (int low = 1; low <= W + 1; low++)
        do_boot(en[0], low);

    for (int en = 0; en < 2; en++)
      for (int mask = 0; mask < 16; mask++)
        for (int ev = 0; ev < 16; ev++) begin
          logic [NE-1:0] q;
          logic exp_enter, exp_take;
          do_boot(en[0], 1);
          reg_wr_en = 1'b1; reg_sel = 1'b0; reg_wdata = 32'hFFFF_FFF0 | mask;
          @(negedge clk);
          reg_wr_en = 1'b0;
          chk("R4 enable write", en_reg_o, 32'hFFFF_FFF0 | mask);
          q         = ev[NE-1:0] & mask[NE-1:0];
          exp_enter = en[0] && (q != 0);
          exp_take  = (ev != 0) && !exp_enter;
          evt_req = ev[NE-1:0];
          @(negedge clk);
          evt_req = '0;
          chk("R5 enter_debug", enter_debug, exp_enter);
          chk("R6 take_interrupt", take_interrupt, exp_take);
          chk("R6 freeze", freeze, (q != 0));
          chk("R5 in_debug", in_debug, exp_enter);
          chk("R7 cause set", cause_o, ev);
          if (exp_enter) begin
            evt_req = '1;
            @(negedge clk);
            evt_req = '0;
            chk("R9 no pulse in debug", {enter_debug, take_interrupt}, 0);
            chk("R9 cause unchanged", cause_o, ev);
          end
          reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = ev;
          @(negedge clk);
          reg_wr_en = 1'b0;
          chk("R7 cause clear", cause_o, 0);
          exit_dbg = 1'b1;
          @(negedge clk);
          exit_dbg = 1'b0;
          chk("R8 exit", {in_debug, freeze}, 0);
        end

    do_boot(1'b0, 1);
    evt_req = 4'b0010; reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = '1;
    @(negedge clk);
    evt_req = '0; reg_wr_en = 1'b0;
    chk("R7 set wins", cause_o, 32'h2);
    chk("R10 single pulse", {enter_debug, take_interrupt}, 2'b01);
    reg_wr_en = 1'b1; reg_wdata = 32'h2;
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk("R7 clear after set", cause_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule